// File: doc/BRIEF.md
# Parity-Checked Mode Register

This block is one byte-wide mode register on a simple parallel host bus. The host writes a byte with one parity bit beside it, and reads the byte back with a parity bit that the block generates. The register holds four live bits. One starts a timed reset of the datapath, one turns on write-parity checking, one selects the clock rate, and one enables scrubbing on trigger. The remaining bit positions are reserved.

When the host sets the reset bit, the block asserts its datapath reset output. It counts byte-time strobes, and after the 32nd strobe it clears the bit by itself. While that reset runs, the register accepts no host writes. When checking is on, a write whose parity is wrong is dropped and raises a sticky error flag, which the host clears with a dedicated input. The clock generator and the scrub sequencer are outside this block; it only drives their control levels.

Top module: `mode_ctl_bank`

## Requirements
- R1: After the asynchronous active-low reset, all four live bits, the datapath reset output, the rate select output, the scrub enable output and the parity error flag are 0.
- R2: A write (bus_wr high) to address 0x1E loads bit 1 (check enable), bit 3 (rate select) and bit 5 (scrub enable) from the write data on the next clock edge. A write to any other address changes nothing.
- R3: A write of 1 to bit 0 at 0x1E sets the reset bit and raises dp_reset. The bit stays set until 32 byte_tick strobes have arrived after the cycle in which it was set. It clears on the clock edge that follows the edge on which the 32nd strobe was taken.
- R4: While the reset bit is set, every host write is ignored: it changes no register bit and does not raise the parity error flag.
- R5: With bit 1 at 0, a write is accepted whatever its parity bit.
- R6: With bit 1 at 1, a write is accepted only if the 8 data bits plus bus_wpar hold an odd number of ones. A failing write is discarded and sets perr_flag. The flag stays set until perr_clr is high on a clock edge with no new error; a new error on the same edge wins.
- R7: rd_data shows the register at address 0x1E and 0 at any other address. Reserved bits 2, 4, 6 and 7 always read 0. rd_par always makes rd_data plus rd_par hold an odd number of ones, whether or not checking is on.
- R8: rate_sel follows bit 3 and scrub_en follows bit 5. The timed datapath reset leaves both of them, and bit 1, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_addr | input | 8 | Host address |
| bus_wdata | input | 8 | Host write data |
| bus_wpar | input | 1 | Host write parity bit (odd) |
| bus_wr | input | 1 | Write strobe, one clock per write |
| perr_clr | input | 1 | Clears the sticky parity error flag |
| byte_tick | input | 1 | Single-cycle byte-time strobe |
| rd_data | output | 8 | Read data for the addressed register |
| rd_par | output | 1 | Generated odd parity of rd_data |
| perr_flag | output | 1 | Sticky write-parity error flag |
| dp_reset | output | 1 | Datapath reset, high while the reset bit is set |
| rate_sel | output | 1 | Clock rate select level |
| scrub_en | output | 1 | Scrub-on-trigger enable level |

## Verification
On every cycle, the assertions check the following. The reset bit holds until the timer reports done and falls right after it. The strobe count never passes its limit. During reset no write is taken or flagged and the configuration bits stay stable. A parity failure is never also taken, and it always leaves the flag set. Read data keeps odd parity and zero reserved bits. Only the bench's scenarios can show the exact count of 32 strobes, that a failing write leaves the old register value in place, that other addresses are ignored, and how clear and a new error interact on the flag.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
  localparam int BIT_RST   = 0;
  localparam int BIT_PCHK  = 1;
  localparam int BIT_RATE  = 3;
  localparam int BIT_SCRUB = 5;
  localparam logic [7:0] LIVE_MASK = (8'd1 << BIT_RST) | (8'd1 << BIT_PCHK)
                                   | (8'd1 << BIT_RATE) | (8'd1 << BIT_SCRUB);

  // parity bit that makes the 9-bit word hold an odd number of ones
  function automatic logic odd_par_bit(input logic [7:0] d);
    return ~(^d);
  endfunction

  // true when data plus parity bit carry odd parity
  function automatic logic odd_par_ok(input logic [7:0] d, input logic p);
    return ^{d, p};
  endfunction
endpackage

// File: rtl/mcb_wr_gate.sv
module mcb_wr_gate
  import mcb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              wr,
  input  logic              addr_hit,
  input  logic              busy,
  input  logic              chk_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wpar,
  output logic              take,
  output logic              perr
);
  logic live_wr;
  logic par_good;

  always_comb begin
    live_wr  = wr && addr_hit && !busy;
    par_good = odd_par_ok(wdata, wpar);
    perr     = live_wr && chk_en && !par_good;
    take     = live_wr && !perr;
  end
endmodule

// File: rtl/mcb_rst_timer.sv
module mcb_rst_timer #(
  parameter int TICKS = 32,
  localparam int CNT_W = $clog2(TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             tick,
  output logic             done,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TICKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!active) begin
      cnt <= '0;
    end else if (tick && cnt != LIMIT) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = active && (cnt == LIMIT);
endmodule

// File: rtl/mcb_readback.sv
module mcb_readback
  import mcb_pkg::*;
(
  input  logic       addr_hit,
  input  logic [7:0] reg_val,
  output logic [7:0] rd_data,
  output logic       rd_par
);
  always_comb begin
    rd_data = addr_hit ? (reg_val & LIVE_MASK) : 8'h00;
    rd_par  = odd_par_bit(rd_data);
  end
endmodule

// File: rtl/mode_ctl_bank.sv
module mode_ctl_bank
  import mcb_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  REG_ADDR  = 8'h1E,
  parameter int          RST_TICKS = 32,
  localparam int         CNT_W     = $clog2(RST_TICKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wpar,
  input  logic              bus_wr,
  input  logic              perr_clr,
  input  logic              byte_tick,
  output logic [7:0]        rd_data,
  output logic              rd_par,
  output logic              perr_flag,
  output logic              dp_reset,
  output logic              rate_sel,
  output logic              scrub_en
);
  logic             rst_q, pchk_q, rate_q, scrub_q, perr_q;
  logic             addr_hit;
  logic             wr_take, wr_perr;
  logic             rst_done;
  logic [CNT_W-1:0] rst_cnt;
  logic [7:0]       reg_val;

  assign addr_hit = (bus_addr == ADDR_W'(REG_ADDR));

  mcb_wr_gate #(.DATA_W(8)) u_gate (
    .wr       (bus_wr),
    .addr_hit (addr_hit),
    .busy     (rst_q),
    .chk_en   (pchk_q),
    .wdata    (bus_wdata),
    .wpar     (bus_wpar),
    .take     (wr_take),
    .perr     (wr_perr)
  );

  mcb_rst_timer #(.TICKS(RST_TICKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (rst_q),
    .tick   (byte_tick),
    .done   (rst_done),
    .cnt    (rst_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q   <= 1'b0;
      pchk_q  <= 1'b0;
      rate_q  <= 1'b0;
      scrub_q <= 1'b0;
    end else if (wr_take) begin
      pchk_q  <= bus_wdata[BIT_PCHK];
      rate_q  <= bus_wdata[BIT_RATE];
      scrub_q <= bus_wdata[BIT_SCRUB];
      if (bus_wdata[BIT_RST]) rst_q <= 1'b1;
    end else if (rst_done) begin
      rst_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        perr_q <= 1'b0;
    else if (wr_perr)  perr_q <= 1'b1;
    else if (perr_clr) perr_q <= 1'b0;
  end

  always_comb begin
    reg_val            = 8'h00;
    reg_val[BIT_RST]   = rst_q;
    reg_val[BIT_PCHK]  = pchk_q;
    reg_val[BIT_RATE]  = rate_q;
    reg_val[BIT_SCRUB] = scrub_q;
  end

  mcb_readback u_rb (
    .addr_hit (addr_hit),
    .reg_val  (reg_val),
    .rd_data  (rd_data),
    .rd_par   (rd_par)
  );

  assign perr_flag = perr_q;
  assign dp_reset  = rst_q;
  assign rate_sel  = rate_q;
  assign scrub_en  = scrub_q;
endmodule

// File: rtl/mcb_checker.sv
module mcb_checker
  import mcb_pkg::*;
#(
  parameter int TICKS = 32,
  localparam int CNT_W = $clog2(TICKS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dp_reset,
  input logic             rst_done,
  input logic [CNT_W-1:0] rst_cnt,
  input logic             wr_take,
  input logic             wr_perr,
  input logic             perr_flag,
  input logic             rate_sel,
  input logic             scrub_en,
  input logic             pchk_q,
  input logic [7:0]       rd_data,
  input logic             rd_par
);
  a_r3_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    dp_reset && !rst_done |=> dp_reset);
  a_r3_clear_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    rst_done |=> !dp_reset);
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cnt <= CNT_W'(TICKS));
  a_r4_no_write_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    dp_reset |-> !wr_take && !wr_perr);
  a_r4_r8_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
    dp_reset |=> $stable({rate_sel, scrub_en, pchk_q}));
  a_r6_err_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    wr_perr |-> !wr_take);
  a_r6_flag_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    wr_perr |=> perr_flag);
  a_r6_err_needs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_perr |-> pchk_q);
  a_r7_odd_parity: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rd_data, rd_par}) % 2 == 1);
  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~LIVE_MASK) == 8'h00);
endmodule

bind mode_ctl_bank mcb_checker #(.TICKS(RST_TICKS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dp_reset  (dp_reset),
  .rst_done  (rst_done),
  .rst_cnt   (rst_cnt),
  .wr_take   (wr_take),
  .wr_perr   (wr_perr),
  .perr_flag (perr_flag),
  .rate_sel  (rate_sel),
  .scrub_en  (scrub_en),
  .pchk_q    (pchk_q),
  .rd_data   (rd_data),
  .rd_par    (rd_par)
);

// File: tb/tb_mode_ctl_bank.sv
module tb_mode_ctl_bank;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_addr, bus_wdata;
  logic       bus_wpar, bus_wr, perr_clr, byte_tick;
  logic [7:0] rd_data;
  logic       rd_par, perr_flag, dp_reset, rate_sel, scrub_en;

  int total = 0;
  int bad   = 0;
  bit finished = 0;
  logic [7:0] m_cfg;
  logic       m_perr;

  localparam logic [7:0] RADDR = 8'h1E;

  always #10 clk = ~clk;

  mode_ctl_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wpar(bus_wpar), .bus_wr(bus_wr), .perr_clr(perr_clr),
    .byte_tick(byte_tick), .rd_data(rd_data), .rd_par(rd_par),
    .perr_flag(perr_flag), .dp_reset(dp_reset), .rate_sel(rate_sel),
    .scrub_en(scrub_en)
  );

  // odd parity bit computed by counting ones
  function automatic logic good_par(input logic [7:0] d);
    int n = 0;
    for (int i = 0; i < 8; i++) n += d[i];
    return (n % 2 == 0);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one clock worth of inputs, return at the following negedge
  task automatic cyc(input logic [7:0] a, input logic [7:0] d, input logic p,
                     input logic wr, input logic clr, input logic tk);
    bus_addr = a; bus_wdata = d; bus_wpar = p; bus_wr = wr;
    perr_clr = clr; byte_tick = tk;
    @(negedge clk);
    bus_addr = RADDR; bus_wr = 1'b0; perr_clr = 1'b0; byte_tick = 1'b0;
    #1;
  endtask

  task automatic wr_good(input logic [7:0] d);
    cyc(RADDR, d, good_par(d), 1'b1, 1'b0, 1'b0);
  endtask

  task automatic wr_bad(input logic [7:0] d);
    cyc(RADDR, d, ~good_par(d), 1'b1, 1'b0, 1'b0);
  endtask

  task automatic chk_read(input string req, input logic [7:0] exp);
    check(req, rd_data, exp);
    check(req, {7'd0, rd_par}, {7'd0, good_par(exp)});
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bus_addr = RADDR; bus_wdata = 0; bus_wpar = 0; bus_wr = 0;
    perr_clr = 0; byte_tick = 0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;

    // R1 reset state
    chk_read("R1", 8'h00);
    check("R1", {4'd0, dp_reset, rate_sel, scrub_en, perr_flag}, 8'h00);

    // R2 R8 write rate and scrub with parity check off
    wr_good(8'h28);
    chk_read("R2", 8'h28);
    check("R8", {6'd0, rate_sel, scrub_en}, 8'h03);

    // R2 other address ignored; R7 other address reads 0
    cyc(8'h1F, 8'hFF, good_par(8'hFF), 1'b1, 1'b0, 1'b0);
    chk_read("R2", 8'h28);
    bus_addr = 8'h1F; #1;
    chk_read("R7", 8'h00);
    bus_addr = RADDR; #1;

    // R5 bad parity accepted while checking is off
    wr_bad(8'h02);
    chk_read("R5", 8'h02);
    check("R5", {7'd0, perr_flag}, 8'h00);

    // R6 checking on: bad write dropped, flag set and sticky
    wr_bad(8'h2A);
    chk_read("R6", 8'h02);
    check("R6", {7'd0, perr_flag}, 8'h01);
    wr_good(8'h0A);
    chk_read("R6", 8'h0A);
    check("R6", {7'd0, perr_flag}, 8'h01);
    cyc(RADDR, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R6", {7'd0, perr_flag}, 8'h00);
    cyc(RADDR, 8'h20, ~good_par(8'h20), 1'b1, 1'b1, 1'b0);
    check("R6 set wins", {7'd0, perr_flag}, 8'h01);
    chk_read("R6", 8'h0A);
    cyc(RADDR, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);

    // R7 reserved bits read zero
    wr_good(8'hD6);
    chk_read("R7", 8'h02);

    // R3 timed reset
    wr_good(8'h2B);
    check("R3", {7'd0, dp_reset}, 8'h01);
    chk_read("R3", 8'h2B);
    // R4 writes ignored during reset
    wr_good(8'h00);
    chk_read("R4", 8'h2B);
    wr_bad(8'h00);
    check("R4", {7'd0, perr_flag}, 8'h00);
    chk_read("R4", 8'h2B);
    for (int i = 0; i < 31; i++) begin
      cyc(RADDR, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
      @(negedge clk); #1;
    end
    check("R3 after 31 ticks", {7'd0, dp_reset}, 8'h01);
    cyc(RADDR, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R3 edge of 32nd tick", {7'd0, dp_reset}, 8'h01);
    @(negedge clk); #1;
    check("R3 cleared", {7'd0, dp_reset}, 8'h00);
    check("R8", {6'd0, rate_sel, scrub_en}, 8'h03);
    chk_read("R8", 8'h2A);

    // R3 ticks in the setting cycle do not count
    cyc(RADDR, 8'h01, good_par(8'h01), 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 31; i++) cyc(RADDR, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R3 set-cycle tick", {7'd0, dp_reset}, 8'h01);
    cyc(RADDR, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
    @(negedge clk); #1;
    check("R3 cleared again", {7'd0, dp_reset}, 8'h00);
    chk_read("R3", 8'h00);

    // random traffic, bit 0 kept clear, compared to bench model
    m_cfg = 8'h00; m_perr = 1'b0;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a, d;
      logic p, wr, clr, pg;
      a   = ($urandom % 3 == 0) ? 8'($urandom) : RADDR;
      d   = 8'($urandom) & 8'hFE;
      pg  = ($urandom % 4 != 0);
      p   = pg ? good_par(d) : ~good_par(d);
      wr  = ($urandom % 2 == 0);
      clr = ($urandom % 6 == 0);
      if (wr && a == RADDR && m_cfg[1] && !pg) m_perr = 1'b1;
      else begin
        if (wr && a == RADDR) m_cfg = d & 8'h2A;
        if (clr) m_perr = 1'b0;
      end
      cyc(a, d, p, wr, clr, 1'b0);
      chk_read("R2 R6 R7 random", m_cfg);
      check("R6 random flag", {7'd0, perr_flag}, {7'd0, m_perr});
      check("R8 random", {6'd0, rate_sel, scrub_en}, {6'd0, m_cfg[3], m_cfg[5]});
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule